// File: doc/BRIEF.md
# Hardware Monitor Control Register Bank

This block is the control register set of a hardware monitor. A host writes to it and reads from it through a plain register port: an 8-bit address, 8-bit write data, a write strobe and a combinational read-data bus. The serial bus front end that feeds this port is outside the block, as are the converter and the measurement sequencing.

The bank holds a configuration register, two status registers, a VID register and a test register. Several of their bits drive control outputs.

- A run enable tells the measurement loop to scan. When it is low, the monitor sits in low-power standby and registers can still be accessed.
- A reset pin gives an active-low pulse when software asks for one.
- A select line sets the function of a shared pin: a 12 V analog input or the fifth VID input.
- A full-shutdown flag is formed from a bit in the VID register and a bit in the test register.
- An offset-routing flag moves the temperature offset from the external sensor channel to the internal one.

Two configuration bits are actions that clear themselves. One starts the reset pulse, timed in ticks of a slow timebase. The other is a soft initialization that restores only the configuration and status registers.

Top module: `hwmon_ctrl_regs`

## Requirements
- R1: After power-on reset (rst_n low), the registers read as follows: configuration (40h) 08h, status 1 (41h) and status 2 (42h) 00h, VID (47h) with bits 7:4 at 0, test (4Ah) 00h. rst_pin_n is 1, and mon_run, vid4_sel, full_shdn and ofs_internal are 0.
- R2: Configuration bit 0 is a read/write start bit. mon_run equals this bit unless full shutdown is active.
- R3: A write of 1 to configuration bit 4 drives rst_pin_n low from the clock edge of the write. It stays low until PULSE_TICKS tick cycles have been seen. Bit 4 always reads back 0.
- R4: A new pulse request during an active pulse reloads the full count of PULSE_TICKS ticks.
- R5: Configuration bit 5 is read/write and drives vid4_sel: 0 selects the 12 V analog input and 1 selects the VID4 input.
- R6: A write with configuration bit 7 set returns the configuration register to 08h and clears both status registers. It discards the other bits of that same write, including bit 4. Bit 7 reads 0, and the VID and test registers keep their contents.
- R7: Configuration bits 1, 2 and 6 read 0 and bit 3 reads 1, and writes to these bits are ignored. Test bits 7:1 and VID bits 5:4 read 0 and ignore writes.
- R8: full_shdn is 1 exactly when VID bit 7 and test bit 0 are both 1. While it is 1, mon_run is 0. Clearing either bit restores the earlier outputs with no register contents lost.
- R9: ofs_internal is 1 exactly when test bit 0 is 1, VID bit 6 is 1 and VID bit 7 is 0. Otherwise the offset stays on the external channel.
- R10: Status bits are set by a 1 on the matching bit of st1_evt or st2_evt and stay set until reset or soft initialization. Bus writes to 41h and 42h are ignored.
- R11: VID bits 3:0 read the live value of vid_pins. Any address not listed in R1 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle strobe of the slow timebase used for pulse timing |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| vid_pins | input | 4 | Live VID[3:0] input levels |
| st1_evt | input | 8 | Set strobes for status register 1 bits |
| st2_evt | input | 8 | Set strobes for status register 2 bits |
| mon_run | output | 1 | Monitoring loop enable |
| rst_pin_n | output | 1 | Active-low reset pulse output |
| vid4_sel | output | 1 | Shared pin function: 1 selects VID4, 0 selects 12 V input |
| full_shdn | output | 1 | Full analog shutdown request |
| ofs_internal | output | 1 | Temperature offset routed to the internal channel |

## Verification
Most wrong internal states show up on a port within one cycle. A bad stored configuration, VID or test bit shows on the next read of that address, and also on mon_run, vid4_sel, full_shdn or ofs_internal right after the write edge. A wrong pulse counter can only be seen by counting ticks until rst_pin_n rises, so the pulse length and the reload on a second request are each measured to the exact tick. A soft initialization that clears too much or too little shows on the first reads of the status, VID and test addresses after it.

// File: rtl/hwmon_ctrl_pkg.sv
package hwmon_ctrl_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 8;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam reg_t CFG_RESET_VAL = 8'h08;

  localparam int START_BIT = 0;
  localparam int PULSE_BIT = 4;
  localparam int SEL_BIT   = 5;
  localparam int INIT_BIT  = 7;

  // shutdown needs both the VID high bit and the test bit
  function automatic logic shdn_decode(input logic vid7, input logic tst0);
    return vid7 & tst0;
  endfunction

  // offset moves inward only with test bit set, VID bit 6 set, VID bit 7 clear
  function automatic logic ofs_decode(input logic vid7, input logic vid6, input logic tst0);
    return tst0 & vid6 & ~vid7;
  endfunction

  // read view of the configuration register; action bits read 0, bit 3 fixed 1
  function automatic reg_t cfg_view(input logic start, input logic sel);
    return {1'b0, 1'b0, sel, 1'b0, 1'b1, 1'b0, 1'b0, start};
  endfunction

endpackage

// File: rtl/hwmon_cfg_reg.sv
module hwmon_cfg_reg
  import hwmon_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  reg_t wdata,
  output logic start_q,
  output logic sel_q,
  output logic init_req,
  output logic pulse_req
);

  assign init_req  = wr & wdata[INIT_BIT];
  assign pulse_req = wr & wdata[PULSE_BIT] & ~wdata[INIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= CFG_RESET_VAL[START_BIT];
      sel_q   <= CFG_RESET_VAL[SEL_BIT];
    end else if (init_req) begin
      start_q <= CFG_RESET_VAL[START_BIT];
      sel_q   <= CFG_RESET_VAL[SEL_BIT];
    end else if (wr) begin
      start_q <= wdata[START_BIT];
      sel_q   <= wdata[SEL_BIT];
    end
  end

endmodule

// File: rtl/hwmon_sticky_status.sv
module hwmon_sticky_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q | evt;
  end

endmodule

// File: rtl/hwmon_rst_pulse.sv
module hwmon_rst_pulse #(
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  output logic active
);

  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (req) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (active && tick) begin
      if (cnt == ONE) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/hwmon_ctrl_regs.sv
module hwmon_ctrl_regs
  import hwmon_ctrl_pkg::*;
#(
  parameter int    PULSE_TICKS = 20,
  parameter addr_t CFG_ADDR    = 8'h40,
  parameter addr_t ST1_ADDR    = 8'h41,
  parameter addr_t ST2_ADDR    = 8'h42,
  parameter addr_t VID_ADDR    = 8'h47,
  parameter addr_t TEST_ADDR   = 8'h4A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [3:0] vid_pins,
  input  logic [7:0] st1_evt,
  input  logic [7:0] st2_evt,
  output logic       mon_run,
  output logic       rst_pin_n,
  output logic       vid4_sel,
  output logic       full_shdn,
  output logic       ofs_internal
);

  localparam int N_STATUS = 2;

  logic cfg_wr, vid_wr, test_wr;
  logic start_q, sel_q;
  logic init_req, pulse_req, pulse_active;
  logic [1:0] vid_hi_q;
  logic test_q;
  reg_t st_q  [N_STATUS];
  reg_t st_evt[N_STATUS];
  reg_t st1_q, st2_q;

  assign cfg_wr  = wr_en && (addr == CFG_ADDR);
  assign vid_wr  = wr_en && (addr == VID_ADDR);
  assign test_wr = wr_en && (addr == TEST_ADDR);

  hwmon_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .wdata     (wdata),
    .start_q   (start_q),
    .sel_q     (sel_q),
    .init_req  (init_req),
    .pulse_req (pulse_req)
  );

  hwmon_rst_pulse #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (pulse_req),
    .tick   (tick),
    .active (pulse_active)
  );

  assign st_evt[0] = st1_evt;
  assign st_evt[1] = st2_evt;

  for (genvar g = 0; g < N_STATUS; g++) begin : g_status
    hwmon_sticky_status #(.W(REG_W)) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (init_req),
      .evt   (st_evt[g]),
      .q     (st_q[g])
    );
  end

  assign st1_q = st_q[0];
  assign st2_q = st_q[1];

  // VID bits 7:6 and test bit 0 survive soft initialization
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_hi_q <= '0;
      test_q   <= 1'b0;
    end else begin
      if (vid_wr)  vid_hi_q <= wdata[7:6];
      if (test_wr) test_q   <= wdata[0];
    end
  end

  assign full_shdn    = shdn_decode(vid_hi_q[1], test_q);
  assign ofs_internal = ofs_decode(vid_hi_q[1], vid_hi_q[0], test_q);
  assign mon_run      = start_q & ~full_shdn;
  assign vid4_sel     = sel_q;
  assign rst_pin_n    = ~pulse_active;

  always_comb begin
    rdata = '0;
    if (addr == CFG_ADDR)       rdata = cfg_view(start_q, sel_q);
    else if (addr == ST1_ADDR)  rdata = st1_q;
    else if (addr == ST2_ADDR)  rdata = st2_q;
    else if (addr == VID_ADDR)  rdata = {vid_hi_q, 2'b00, vid_pins};
    else if (addr == TEST_ADDR) rdata = {7'b0, test_q};
  end

endmodule

// File: rtl/hwmon_ctrl_regs_chk.sv
module hwmon_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       init_req,
  input logic       pulse_req,
  input logic       rst_pin_n,
  input logic       mon_run,
  input logic       vid4_sel,
  input logic       full_shdn,
  input logic       ofs_internal,
  input logic [7:0] st1_q,
  input logic [7:0] st2_q
);

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |=> !rst_pin_n);

  // R3
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin_n) |-> $past(tick));

  // R6
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (!vid4_sel && !mon_run && st1_q == 8'h00 && st2_q == 8'h00));

  // R8
  shdn_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_shdn |-> !mon_run);

  // R9
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_shdn && ofs_internal));

  // R10
  sticky_st1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_req) |-> ((st1_q & $past(st1_q)) == $past(st1_q)));

  // R10
  sticky_st2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_req) |-> ((st2_q & $past(st2_q)) == $past(st2_q)));

endmodule

bind hwmon_ctrl_regs hwmon_ctrl_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .init_req     (init_req),
  .pulse_req    (pulse_req),
  .rst_pin_n    (rst_pin_n),
  .mon_run      (mon_run),
  .vid4_sel     (vid4_sel),
  .full_shdn    (full_shdn),
  .ofs_internal (ofs_internal),
  .st1_q        (st1_q),
  .st2_q        (st2_q)
);

// File: tb/hwmon_ctrl_regs_test.sv
module hwmon_ctrl_regs_test;

  localparam int N_TICKS = 20;
  localparam int NV = 14;

  // {we, waddr, wdata, raddr, exp_rdata, exp {mon_run, vid4_sel, full_shdn, ofs_internal}}
  localparam logic [36:0] VEC [0:NV-1] = '{
    {1'b1, 8'h40, 8'h01, 8'h40, 8'h09, 4'b1000},  // R2
    {1'b1, 8'h40, 8'h67, 8'h40, 8'h29, 4'b1100},  // R5 R7
    {1'b1, 8'h47, 8'h80, 8'h47, 8'h8A, 4'b1100},  // R11
    {1'b1, 8'h4A, 8'h01, 8'h4A, 8'h01, 4'b0110},  // R8
    {1'b1, 8'h47, 8'h40, 8'h47, 8'h4A, 4'b1101},  // R9
    {1'b1, 8'h4A, 8'hFF, 8'h4A, 8'h01, 4'b1101},  // R7
    {1'b1, 8'h47, 8'hC0, 8'h47, 8'hCA, 4'b0110},  // R8
    {1'b1, 8'h47, 8'h3F, 8'h40, 8'h29, 4'b1100},  // R8
    {1'b0, 8'h00, 8'h00, 8'h47, 8'h0A, 4'b1100},  // R7
    {1'b1, 8'h40, 8'hA1, 8'h40, 8'h08, 4'b0000},  // R6
    {1'b0, 8'h00, 8'h00, 8'h4A, 8'h01, 4'b0000},  // R6
    {1'b1, 8'h47, 8'h40, 8'h47, 8'h4A, 4'b0001},  // R9
    {1'b0, 8'h00, 8'h00, 8'h10, 8'h00, 4'b0001},  // R11
    {1'b1, 8'h41, 8'hFF, 8'h41, 8'h00, 4'b0001}   // R10
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R2";  1: return "R5/R7"; 2: return "R11"; 3: return "R8";
      4: return "R9";  5: return "R7";    6: return "R8";  7: return "R8";
      8: return "R7";  9: return "R6";    10: return "R6"; 11: return "R9";
      12: return "R11"; default: return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] vid_pins = 4'hA;
  logic [7:0] st1_evt = '0;
  logic [7:0] st2_evt = '0;
  logic mon_run, rst_pin_n, vid4_sel, full_shdn, ofs_internal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hwmon_ctrl_regs #(.PULSE_TICKS(N_TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vid_pins(vid_pins), .st1_evt(st1_evt),
    .st2_evt(st2_evt), .mon_run(mon_run), .rst_pin_n(rst_pin_n),
    .vid4_sel(vid4_sel), .full_shdn(full_shdn), .ofs_internal(ofs_internal)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {4'b0, mon_run, vid4_sel, full_shdn, ofs_internal};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    logic [7:0] v;
    rd(8'h40, v); check("R1 cfg", v, 8'h08);
    rd(8'h41, v); check("R1 st1", v, 8'h00);
    rd(8'h42, v); check("R1 st2", v, 8'h00);
    rd(8'h47, v); check("R1 vid", v, 8'h0A);
    rd(8'h4A, v); check("R1 test", v, 8'h00);
    check("R1 rst_pin_n", {7'b0, rst_pin_n}, 8'h01);
    check("R1 outputs", outs(), 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    apply_reset();
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      logic [36:0] e;
      e = VEC[i];
      @(negedge clk);
      wr_en = e[36]; addr = e[35:28]; wdata = e[27:20];
      @(posedge clk);
      #1 wr_en = 1'b0; addr = e[19:12];
      #1;
      check({vec_req(i), " rdata"}, rdata, e[11:4]);
      check({vec_req(i), " outs"}, outs(), {4'b0, e[3:0]});
    end

    // R3: pulse length and self-clearing bit
    do_write(8'h40, 8'h10);
    check("R3 low after request", {7'b0, rst_pin_n}, 8'h00);
    rd(8'h40, v); check("R3 bit4 reads 0", v, 8'h08);
    pulse_ticks(N_TICKS - 1);
    check("R3 still low", {7'b0, rst_pin_n}, 8'h00);
    pulse_ticks(1);
    check("R3 released", {7'b0, rst_pin_n}, 8'h01);

    // R4: retrigger reloads
    do_write(8'h40, 8'h10);
    pulse_ticks(5);
    do_write(8'h40, 8'h10);
    pulse_ticks(N_TICKS - 1);
    check("R4 still low", {7'b0, rst_pin_n}, 8'h00);
    pulse_ticks(1);
    check("R4 released", {7'b0, rst_pin_n}, 8'h01);

    // R10: sticky status
    @(negedge clk); st1_evt = 8'h05;
    @(negedge clk); st1_evt = 8'h00;
    rd(8'h41, v); check("R10 st1 set", v, 8'h05);
    @(negedge clk); st1_evt = 8'h10; st2_evt = 8'h80;
    @(negedge clk); st1_evt = 8'h00; st2_evt = 8'h00;
    rd(8'h41, v); check("R10 st1 sticky", v, 8'h15);
    rd(8'h42, v); check("R10 st2 set", v, 8'h80);
    do_write(8'h42, 8'h00);
    rd(8'h42, v); check("R10 st2 write ignored", v, 8'h80);

    // R6: init clears status
    do_write(8'h40, 8'h80);
    rd(8'h41, v); check("R6 st1 cleared", v, 8'h00);
    rd(8'h42, v); check("R6 st2 cleared", v, 8'h00);
    rd(8'h47, v); check("R6 vid kept", v, 8'h4A);

    // R11: live VID pins
    vid_pins = 4'h5;
    rd(8'h47, v); check("R11 vid pins", v, 8'h45);

    // R1: power-on reset clears VID and test
    do_write(8'h47, 8'hC0);
    do_write(8'h40, 8'h31);
    apply_reset();
    vid_pins = 4'hA;
    check_reset_state();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule